// File: doc/BRIEF.md
# TDM Receive Channel Selection

This block sits next to the receiver of a time-division-multiplexed serial port. It counts channel slots inside a frame and decides, for every completed word from the deserializer, whether the word is delivered or dropped. A frame holds up to 128 channels. A frame-sync input restarts the count. A channel-boundary strobe marks each completed word and moves the count forward.

When channel selection is off, every word inside the programmed frame length is delivered. When it is on, words are gated by enable masks. In eight-partition mode each group of 16 consecutive channels has its own mask. In two-partition mode one even-numbered group is bound to partition A and one odd-numbered group to partition B, each with its own mask. Groups then take turns, A first, through the frame.

A delivered word leaves as a single-cycle `acc_valid` pulse, with its data cut to the word length and its channel number. This pulse writes the receive buffer. It also sets the sticky `rx_ready` flag, which the buffer read clears. The output has no back-pressure: the buffer must take every pulse, and `acc_data`/`acc_chan` are only meaningful while `acc_valid` is high.

Top module: `tdm_rx_chsel`

## Requirements
- R1: After reset, `acc_valid` and `rx_ready` are 0. Words that complete before the first frame-sync are dropped.
- R2: Frame-sync makes the next word channel 0, and each word strobe advances the channel by one. A word whose strobe coincides with frame-sync still belongs to the old frame. `acc_chan` reports the channel of the delivered word.
- R3: Words with a channel index above `frame_len_m1` (frame length minus one) are dropped until the next frame-sync.
- R4: With `sel_en`=0, every in-frame word is delivered, whatever the masks, mode and assignments.
- R5: With `sel_en`=1 and `part8`=1, channel n is delivered only if `en_mask[n]` is 1. That bit is bit n mod 16 of the mask for group n/16.
- R6: With `sel_en`=1 and `part8`=0, a channel in an even group g is delivered only if g == 2*`pa_blk` and `en_mask[n mod 16]` is 1. A channel in an odd group g is delivered only if g == 2*`pb_blk`+1 and `en_mask[16 + n mod 16]` is 1. Any group not assigned is dropped.
- R7: In two-partition mode, groups alternate A, B, A, … from frame-sync, so channels 0–15 always fall to partition A.
- R8: `acc_valid` is a one-cycle pulse in the cycle after the accepted word's strobe. `acc_data` equals `word_in` with all bits at index ≥ `word_len`+1 forced to 0 (`word_len` is the word length minus one).
- R9: `rx_ready` goes to 1 with each `acc_valid`. It stays at 1 until a cycle with `buf_rd`=1 and no new accept, and a dropped word never changes it. An accept in the same cycle as `buf_rd` leaves it at 1.
- R10: With frame length 40, eight-partition selection and only channels 0, 15 and 39 enabled, exactly three words are delivered per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame-sync pulse, restarts the channel count |
| word_done | input | 1 | Word completed on the serial line |
| word_in | input | WORD_W | Deserialized word, valid with `word_done` |
| word_len | input | $clog2(WORD_W) | Word length minus one |
| frame_len_m1 | input | $clog2(NCHAN) | Frame length minus one, in channels |
| sel_en | input | 1 | 1 = masks gate channels, 0 = all channels open |
| part8 | input | 1 | 1 = eight-partition mode, 0 = two-partition mode |
| pa_blk | input | $clog2(NCHAN/BLK_W)-1 | Partition A group is 2*pa_blk |
| pb_blk | input | $clog2(NCHAN/BLK_W)-1 | Partition B group is 2*pb_blk+1 |
| en_mask | input | NCHAN | Enable masks, 16 bits per slot |
| buf_rd | input | 1 | Receive buffer read, clears `rx_ready` |
| acc_valid | output | 1 | One-cycle accept pulse |
| acc_data | output | WORD_W | Accepted word, length-trimmed |
| acc_chan | output | $clog2(NCHAN) | Channel of the accepted word |
| rx_ready | output | 1 | Sticky ready flag |

## Verification
The bench uses the default parameters: 128 channels in groups of 16 and 32-bit words. Frame lengths can reach the full 128 channels, so all eight groups, both partition slots and every A/B pairing can be hit. Word lengths from 1 to 32 bits exercise the trim at both ends. Random configurations run in all three gating modes, and directed frames cover the three-channel example, words past the frame end, frame-sync on a word strobe, and buffer reads that coincide with an accept.

// File: rtl/tdm_rx_chsel_pkg.sv
package tdm_rx_chsel_pkg;

  typedef enum logic {
    PART_TWO   = 1'b0,
    PART_EIGHT = 1'b1
  } part_mode_e;

  typedef enum logic {
    GATE_OPEN   = 1'b0,
    GATE_MASKED = 1'b1
  } gate_mode_e;

endpackage

// File: rtl/tdm_chan_tracker.sv
module tdm_chan_tracker #(
  parameter int CHAN_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              word_done,
  input  logic [CHAN_W-1:0] frame_len_m1,
  output logic [CHAN_W-1:0] cur_chan,
  output logic              in_frame
);

  logic [CHAN_W-1:0] chan_q;
  logic              live_q;
  logic              at_end;

  assign at_end = (chan_q == frame_len_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_q <= '0;
      live_q <= 1'b0;
    end else if (fsync) begin
      chan_q <= '0;
      live_q <= 1'b1;
    end else if (word_done && live_q) begin
      if (at_end) begin
        live_q <= 1'b0;
      end else begin
        chan_q <= chan_q + 1'b1;
      end
    end
  end

  assign cur_chan = chan_q;
  assign in_frame = live_q;

endmodule

// File: rtl/tdm_chan_gate.sv
module tdm_chan_gate
  import tdm_rx_chsel_pkg::*;
#(
  parameter int NCHAN = 128,
  parameter int BLK_W = 16,
  localparam int CHAN_W = $clog2(NCHAN),
  localparam int LANE_W = $clog2(BLK_W),
  localparam int NBLK   = NCHAN / BLK_W,
  localparam int BIDX_W = CHAN_W - LANE_W,
  localparam int PSEL_W = (BIDX_W > 1) ? BIDX_W - 1 : 1
) (
  input  logic [CHAN_W-1:0] chan,
  input  logic              sel_en,
  input  logic              part8,
  input  logic [PSEL_W-1:0] pa_blk,
  input  logic [PSEL_W-1:0] pb_blk,
  input  logic [NCHAN-1:0]  en_mask,
  output logic              chan_en
);

  logic [BIDX_W-1:0] blk;
  logic [LANE_W-1:0] lane;
  logic [PSEL_W-1:0] pair;
  logic              odd_blk;
  logic [NBLK-1:0]   blk_hit;
  logic              en8;
  logic              en2;
  part_mode_e        pmode;
  gate_mode_e        gmode;

  assign blk     = chan[CHAN_W-1:LANE_W];
  assign lane    = chan[LANE_W-1:0];
  assign pair    = blk[BIDX_W-1:1];
  assign odd_blk = blk[0];
  assign pmode   = part_mode_e'(part8);
  assign gmode   = gate_mode_e'(sel_en);

  // One mask slot per group in eight-partition mode.
  for (genvar k = 0; k < NBLK; k++) begin : g_blk
    logic [BLK_W-1:0] slot;
    assign slot       = en_mask[k*BLK_W +: BLK_W];
    assign blk_hit[k] = (blk == BIDX_W'(k)) && slot[lane];
  end

  logic [BLK_W-1:0] mask_a;
  logic [BLK_W-1:0] mask_b;
  assign mask_a = en_mask[0 +: BLK_W];
  assign mask_b = en_mask[BLK_W +: BLK_W];

  always_comb begin
    en8 = |blk_hit;
    if (odd_blk) begin
      en2 = (pair == pb_blk) && mask_b[lane];
    end else begin
      en2 = (pair == pa_blk) && mask_a[lane];
    end
    if (gmode == GATE_OPEN) begin
      chan_en = 1'b1;
    end else if (pmode == PART_EIGHT) begin
      chan_en = en8;
    end else begin
      chan_en = en2;
    end
  end

endmodule

// File: rtl/tdm_word_capture.sv
module tdm_word_capture #(
  parameter int WORD_W = 32,
  parameter int CHAN_W = 7,
  localparam int LEN_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [WORD_W-1:0] word_in,
  input  logic [LEN_W-1:0]  word_len,
  input  logic [CHAN_W-1:0] chan,
  input  logic              buf_rd,
  output logic              acc_valid,
  output logic [WORD_W-1:0] acc_data,
  output logic [CHAN_W-1:0] acc_chan,
  output logic              rx_ready
);

  logic [WORD_W-1:0] keep;

  for (genvar i = 0; i < WORD_W; i++) begin : g_keep
    assign keep[i] = (LEN_W'(i) <= word_len);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_data  <= '0;
      acc_chan  <= '0;
    end else begin
      acc_valid <= take;
      if (take) begin
        acc_data <= word_in & keep;
        acc_chan <= chan;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_ready <= 1'b0;
    end else if (take) begin
      rx_ready <= 1'b1;
    end else if (buf_rd) begin
      rx_ready <= 1'b0;
    end
  end

endmodule

// File: rtl/tdm_rx_chsel.sv
module tdm_rx_chsel #(
  parameter int NCHAN  = 128,
  parameter int BLK_W  = 16,
  parameter int WORD_W = 32,
  localparam int CHAN_W = $clog2(NCHAN),
  localparam int LEN_W  = $clog2(WORD_W),
  localparam int BIDX_W = CHAN_W - $clog2(BLK_W),
  localparam int PSEL_W = (BIDX_W > 1) ? BIDX_W - 1 : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              word_done,
  input  logic [WORD_W-1:0] word_in,
  input  logic [LEN_W-1:0]  word_len,
  input  logic [CHAN_W-1:0] frame_len_m1,
  input  logic              sel_en,
  input  logic              part8,
  input  logic [PSEL_W-1:0] pa_blk,
  input  logic [PSEL_W-1:0] pb_blk,
  input  logic [NCHAN-1:0]  en_mask,
  input  logic              buf_rd,
  output logic              acc_valid,
  output logic [WORD_W-1:0] acc_data,
  output logic [CHAN_W-1:0] acc_chan,
  output logic              rx_ready
);

  logic [CHAN_W-1:0] cur_chan;
  logic              in_frame;
  logic              chan_en;
  logic              take;

  tdm_chan_tracker #(.CHAN_W(CHAN_W)) u_trk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fsync        (fsync),
    .word_done    (word_done),
    .frame_len_m1 (frame_len_m1),
    .cur_chan     (cur_chan),
    .in_frame     (in_frame)
  );

  tdm_chan_gate #(.NCHAN(NCHAN), .BLK_W(BLK_W)) u_gate (
    .chan    (cur_chan),
    .sel_en  (sel_en),
    .part8   (part8),
    .pa_blk  (pa_blk),
    .pb_blk  (pb_blk),
    .en_mask (en_mask),
    .chan_en (chan_en)
  );

  assign take = word_done && in_frame && chan_en;

  tdm_word_capture #(.WORD_W(WORD_W), .CHAN_W(CHAN_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .word_in   (word_in),
    .word_len  (word_len),
    .chan      (cur_chan),
    .buf_rd    (buf_rd),
    .acc_valid (acc_valid),
    .acc_data  (acc_data),
    .acc_chan  (acc_chan),
    .rx_ready  (rx_ready)
  );

endmodule

// File: rtl/tdm_rx_chsel_chk.sv
module tdm_rx_chsel_chk #(
  parameter int WORD_W = 32,
  parameter int CHAN_W = 7,
  localparam int LEN_W = $clog2(WORD_W)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_done,
  input logic [LEN_W-1:0]  word_len,
  input logic [CHAN_W-1:0] frame_len_m1,
  input logic              sel_en,
  input logic              buf_rd,
  input logic              in_frame,
  input logic              acc_valid,
  input logic [WORD_W-1:0] acc_data,
  input logic [CHAN_W-1:0] acc_chan,
  input logic              rx_ready
);

  AST_ACC_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> $past(word_done)); // R8

  AST_DROP_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $past(word_done && !in_frame) |-> !acc_valid); // R3

  AST_OPEN_ACCEPTS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(word_done && in_frame && !sel_en) |-> acc_valid); // R4

  AST_CHAN_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (acc_chan <= $past(frame_len_m1))); // R2

  AST_DATA_TRIMMED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (((acc_data >> $past(word_len)) >> 1) == '0)); // R8

  AST_READY_WITH_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> rx_ready); // R9

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rx_ready) && !$past(buf_rd)) |-> rx_ready); // R9

  AST_READY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(buf_rd) && !acc_valid) |-> !rx_ready); // R9

endmodule

bind tdm_rx_chsel tdm_rx_chsel_chk #(.WORD_W(WORD_W), .CHAN_W(CHAN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .word_done    (word_done),
  .word_len     (word_len),
  .frame_len_m1 (frame_len_m1),
  .sel_en       (sel_en),
  .buf_rd       (buf_rd),
  .in_frame     (in_frame),
  .acc_valid    (acc_valid),
  .acc_data     (acc_data),
  .acc_chan     (acc_chan),
  .rx_ready     (rx_ready)
);

// File: tb/tb_tdm_rx_chsel.sv
`timescale 1ns/1ps
module tb_tdm_rx_chsel;

  localparam int NCHAN  = 128;
  localparam int BLK_W  = 16;
  localparam int WORD_W = 32;
  localparam int CHAN_W = 7;
  localparam int LEN_W  = 5;
  localparam int PSEL_W = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              fsync;
  logic              word_done;
  logic [WORD_W-1:0] word_in;
  logic [LEN_W-1:0]  word_len;
  logic [CHAN_W-1:0] frame_len_m1;
  logic              sel_en;
  logic              part8;
  logic [PSEL_W-1:0] pa_blk;
  logic [PSEL_W-1:0] pb_blk;
  logic [NCHAN-1:0]  en_mask;
  logic              buf_rd;
  logic              acc_valid;
  logic [WORD_W-1:0] acc_data;
  logic [CHAN_W-1:0] acc_chan;
  logic              rx_ready;

  always #4 clk = ~clk;

  tdm_rx_chsel #(.NCHAN(NCHAN), .BLK_W(BLK_W), .WORD_W(WORD_W)) dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .word_done(word_done),
    .word_in(word_in), .word_len(word_len), .frame_len_m1(frame_len_m1),
    .sel_en(sel_en), .part8(part8), .pa_blk(pa_blk), .pb_blk(pb_blk),
    .en_mask(en_mask), .buf_rd(buf_rd), .acc_valid(acc_valid),
    .acc_data(acc_data), .acc_chan(acc_chan), .rx_ready(rx_ready)
  );

  int  n_cmp = 0;
  int  n_bad = 0;
  int  acc_cnt = 0;
  bit  done = 0;
  int  chan_m = 0;
  bit  live_m = 0;
  bit  rdy_m = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_en(input int ch);
    int blk, lane;
    blk  = ch / BLK_W;
    lane = ch % BLK_W;
    if (!sel_en) return 1'b1;
    if (part8) return en_mask[ch];
    if (blk % 2 == 0) return (blk / 2 == int'(pa_blk)) && en_mask[lane];
    return (blk / 2 == int'(pb_blk)) && en_mask[BLK_W + lane];
  endfunction

  function automatic longint trim(input longint w, input int wl);
    return w & ((64'd1 << (wl + 1)) - 1);
  endfunction

  // One clock: drive at negedge, check after the edge.
  task automatic step(input bit fs, input bit wd, input bit rd, input string tag);
    bit     e_acc;
    int     e_ch;
    longint w;
    @(negedge clk);
    fsync = fs; word_done = wd; buf_rd = rd;
    w = longint'($urandom);
    word_in = w[WORD_W-1:0];
    e_acc = wd && live_m && exp_en(chan_m);
    e_ch  = chan_m;
    @(posedge clk);
    #1;
    chk(tag, longint'(acc_valid), longint'(e_acc));
    if (acc_valid) acc_cnt++;
    if (e_acc) begin
      chk("R8 data", longint'(acc_data), trim(w, int'(word_len)));
      chk("R2 chan", longint'(acc_chan), longint'(e_ch));
    end
    rdy_m = e_acc ? 1'b1 : (rd ? 1'b0 : rdy_m);
    chk("R9 ready", longint'(rx_ready), longint'(rdy_m));
    if (fs) begin
      chan_m = 0; live_m = 1'b1;
    end else if (wd && live_m) begin
      if (chan_m == int'(frame_len_m1)) live_m = 1'b0;
      else chan_m++;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; fsync = 0; word_done = 0; word_in = '0; word_len = 5'd31;
    frame_len_m1 = 7'd127; sel_en = 0; part8 = 0; pa_blk = 0; pb_blk = 0;
    en_mask = '0; buf_rd = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset valid", longint'(acc_valid), 0);
    chk("R1 reset ready", longint'(rx_ready), 0);
    @(negedge clk); rst_n = 1'b1;
    // R1: words before any frame-sync are dropped
    for (int i = 0; i < 4; i++) step(0, 1, 0, "R1 pre-sync");

    // R10: frame of 40, channels 0,15,39 open, extra words dropped (R3)
    sel_en = 1; part8 = 1; frame_len_m1 = 7'd39; word_len = 5'd15;
    en_mask = '0; en_mask[0] = 1; en_mask[15] = 1; en_mask[39] = 1;
    for (int f = 0; f < 2; f++) begin
      step(1, 0, 0, "R2 sync");
      acc_cnt = 0;
      for (int i = 0; i < 40; i++) step(0, 1, (i % 7) == 3, "R10 frame");
      chk("R10 count", longint'(acc_cnt), 3);
      for (int i = 0; i < 5; i++) step(0, 1, 0, "R3 past end");
    end

    // R7: two-partition alternation, A=group 2, B=group 1
    sel_en = 1; part8 = 0; pa_blk = 2'd1; pb_blk = 2'd0; frame_len_m1 = 7'd63;
    en_mask = '0; en_mask[BLK_W-1:0] = 16'hFFFF; en_mask[2*BLK_W-1:BLK_W] = 16'hFFFF;
    step(1, 0, 1, "R2 sync");
    for (int i = 0; i < 64; i++) step(0, 1, 0, "R7 alternate");

    // R2: frame-sync on a word strobe keeps that word in the old frame
    sel_en = 0; frame_len_m1 = 7'd20;
    step(1, 0, 0, "R2 sync");
    for (int i = 0; i < 5; i++) step(0, 1, 0, "R2 count");
    step(1, 1, 0, "R2 sync+word");
    step(0, 1, 0, "R2 restart");
    // R9: read in the same cycle as an accept keeps ready set
    step(0, 1, 1, "R9 read+accept");
    step(0, 0, 1, "R9 read");
    step(0, 0, 0, "R9 idle");

    // Random configurations
    for (int c = 0; c < 12; c++) begin
      string tag;
      sel_en = ($urandom % 4) != 0;
      part8  = $urandom % 2;
      pa_blk = PSEL_W'($urandom);
      pb_blk = PSEL_W'($urandom);
      en_mask = {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
      frame_len_m1 = (c % 3 == 0) ? 7'd127 : CHAN_W'($urandom);
      word_len = LEN_W'($urandom);
      tag = !sel_en ? "R4 open" : (part8 ? "R5 eight" : "R6 two");
      for (int f = 0; f < 2; f++) begin
        step(1, 0, 0, "R2 sync");
        for (int i = 0; i <= int'(frame_len_m1) + 3; i++) begin
          int gap;
          gap = $urandom % 3;
          for (int g = 0; g < gap; g++) step(0, 0, ($urandom % 4) == 0, "R9 gap");
          step(0, 1, ($urandom % 5) == 0, i > int'(frame_len_m1) ? "R3 tail" : tag);
        end
      end
    end
    finish_run();
  end

endmodule